// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a processor goes after each control-flow instruction. It receives the program counter of the instruction, a 4-bit operation code produced by the decoder, the two source operands, the short and long immediate fields, the register number of the destination, and the three saved return addresses. These are the return-address register, the exception-return register and the breakpoint-return register. From these inputs it produces the next program counter, a flag that says whether the flow was redirected, a link-register write (enable, register number and value), and a strobe that tells the core to restore its status word from the saved copy.

The unit is purely combinational. All of its outputs belong to the inputs presented in the same cycle, so a pipeline stage can place it between its operand registers and the fetch redirect. Fetch, flushing and the register file sit outside the block. Conditional branches are evaluated by a comparator stage. A parameter selects either one shared subtractor or separate native comparators for that stage.

Operation codes (op_i): 0 none, 1 unconditional relative branch, 2 signed greater-or-equal, 3 signed less-than, 4 not-equal, 5 equal, 6 unsigned greater-or-equal, 7 unsigned less-than, 8 absolute jump, 9 absolute call, 10 register jump, 11 register call, 12 subroutine return, 13 breakpoint return, 14 exception return, 15 next-PC query.

Top module: `bnpc_unit`

## Requirements
- R1: For op 0, for op 15, and for any conditional branch (ops 2 to 7) whose condition is false, taken_o is 0 and next_pc_o is pc_i + 4.
- R2: For op 1, and for a conditional branch whose condition is true, taken_o is 1 and next_pc_o is pc_i + 4 + (sign-extended imm16_i with bits 1:0 forced to 0).
- R3: The conditions compare rs_a_i against rs_b_i: op 2 a>=b signed, op 3 a<b signed, op 4 a!=b, op 5 a==b, op 6 a>=b unsigned, op 7 a<b unsigned.
- R4: For op 8, taken_o is 1 and next_pc_o is {pc_i[31:28], imm26_i, 2'b00}.
- R5: For op 9, next_pc_o is formed as in R4 and the unit writes pc_i + 4 to register 31 (link_we_o=1, link_idx_o=31).
- R6: For op 10, next_pc_o is rs_a_i unchanged, low bits included. Op 11 does the same and also writes pc_i + 4 to register 31.
- R7: Op 12 takes next_pc_o from ra_val_i, and op 13 takes it from ba_val_i. Both set taken_o and perform no link write.
- R8: Op 14 takes next_pc_o from ea_val_i with taken_o=1 and raises status_restore_o. status_restore_o is 0 for every other operation.
- R9: Op 15 writes pc_i + 4 to register rc_idx_i and is not taken. When rc_idx_i is 0 the write is dropped (link_we_o=0).
- R10: link_we_o is 1 only for ops 9, 11, and 15 with a nonzero rc_idx_i. Whenever it is 1, link_val_o is pc_i + 4.
- R11: All PC arithmetic wraps modulo 2^32. For example, pc_i=0xFFFFFFFC with op 0 gives next_pc_o 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| op_i | input | 4 | Decoded control-flow operation code |
| rs_a_i | input | 32 | First source operand (compare operand and indirect target) |
| rs_b_i | input | 32 | Second source operand (compare operand) |
| imm16_i | input | 16 | Signed relative branch displacement in bytes |
| imm26_i | input | 26 | Word index for the absolute jump and call |
| rc_idx_i | input | 5 | Destination register number for the next-PC query |
| ra_val_i | input | 32 | Current return-address register value |
| ea_val_i | input | 32 | Current exception-return register value |
| ba_val_i | input | 32 | Current breakpoint-return register value |
| taken_o | output | 1 | Flow leaves the sequential path |
| next_pc_o | output | 32 | Address of the next instruction to fetch |
| link_we_o | output | 1 | Register write request for the link value |
| link_idx_o | output | 5 | Register number of the link write |
| link_val_o | output | 32 | Value to write (pc_i + 4) |
| status_restore_o | output | 1 | Copy the saved status word into the status register |

## Verification
Every result of this unit is due in the same cycle as its inputs, with zero register stages between any input and any output. The bench therefore changes the inputs just after a falling clock edge and samples all outputs a quarter period later, before the next rising edge. No output is expected to depend on an earlier vector. The comparator boundaries (equal operands, sign-bit crossings, the most negative against the most positive value) and the address wrap at the top of memory are all checked in that same window.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    CF_NONE   = 4'd0,
    CF_BR     = 4'd1,
    CF_BGE    = 4'd2,
    CF_BLT    = 4'd3,
    CF_BNE    = 4'd4,
    CF_BEQ    = 4'd5,
    CF_BGEU   = 4'd6,
    CF_BLTU   = 4'd7,
    CF_JABS   = 4'd8,
    CF_CABS   = 4'd9,
    CF_JREG   = 4'd10,
    CF_CREG   = 4'd11,
    CF_RETSUB = 4'd12,
    CF_RETBRK = 4'd13,
    CF_RETEXC = 4'd14,
    CF_NEXTPC = 4'd15
  } cf_op_e;

  typedef enum logic [1:0] {
    TGT_SEQ = 2'd0,
    TGT_REL = 2'd1,
    TGT_ABS = 2'd2,
    TGT_IND = 2'd3
  } tgt_sel_e;

  function automatic logic op_is_cond(cf_op_e op);
    return (op == CF_BGE) || (op == CF_BLT) || (op == CF_BNE) ||
           (op == CF_BEQ) || (op == CF_BGEU) || (op == CF_BLTU);
  endfunction

  function automatic logic op_is_indirect(cf_op_e op);
    return (op == CF_JREG) || (op == CF_CREG) || (op == CF_RETSUB) ||
           (op == CF_RETBRK) || (op == CF_RETEXC);
  endfunction

endpackage

// File: rtl/bnpc_target_gen.sv
module bnpc_target_gen #(
  parameter int XLEN    = 32,
  parameter int IMM16_W = 16,
  parameter int IMM26_W = 26,
  parameter int SEG_W   = 4,
  parameter int ALIGN_W = 2
) (
  input  logic [XLEN-1:0]    pc,
  input  logic [IMM16_W-1:0] imm16,
  input  logic [IMM26_W-1:0] imm26,
  output logic [XLEN-1:0]    seq_pc,
  output logic [XLEN-1:0]    rel_pc,
  output logic [XLEN-1:0]    abs_pc
);

  localparam int              INSN_BYTES = 1 << ALIGN_W;
  localparam logic [XLEN-1:0] STEP       = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~(STEP - XLEN'(1));
  localparam logic [XLEN-1:0] SEG_MASK   = ~((XLEN'(1) << (XLEN - SEG_W)) - XLEN'(1));

  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] p);
    return p + STEP;
  endfunction

  function automatic logic [XLEN-1:0] f_sext16(input logic [IMM16_W-1:0] v);
    return {{(XLEN-IMM16_W){v[IMM16_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_rel(input logic [XLEN-1:0] p,
                                            input logic [IMM16_W-1:0] v);
    return f_seq(p) + (f_sext16(v) & ALIGN_MASK);
  endfunction

  function automatic logic [XLEN-1:0] f_abs(input logic [XLEN-1:0] p,
                                            input logic [IMM26_W-1:0] v);
    logic [XLEN-1:0] field;
    field = XLEN'(v) << ALIGN_W;
    return (p & SEG_MASK) | (field & ~SEG_MASK);
  endfunction

  assign seq_pc = f_seq(pc);
  assign rel_pc = f_rel(pc, imm16);
  assign abs_pc = f_abs(pc, imm26);

  logic [XLEN-1:0] rel_delta;
  logic [XLEN-1:0] seq_delta;
  assign rel_delta = rel_pc - seq_pc;
  assign seq_delta = seq_pc - pc;

  always_comb begin
    AST_REL_STEP_ALIGNED: assert ((rel_delta & ~ALIGN_MASK) == '0)
      else $error("relative displacement not word aligned"); // R2
    AST_ABS_SEGMENT_KEPT: assert (((abs_pc ^ pc) & SEG_MASK) == '0)
      else $error("absolute target lost segment bits"); // R4
    AST_ABS_ALIGNED: assert ((abs_pc & ~ALIGN_MASK) == '0)
      else $error("absolute target not word aligned"); // R4
    AST_SEQ_WRAPS: assert (seq_delta == STEP)
      else $error("sequential step not modular"); // R11
  end

endmodule

// File: rtl/bnpc_cond_eval.sv
module bnpc_cond_eval
  import bnpc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SHARED_CMP = 1'b1
) (
  input  cf_op_e          op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            cond_true
);

  localparam int MSB = XLEN - 1;

  logic ge_s, lt_s, eq_v, ne_v, ge_u, lt_u;

  generate
    if (SHARED_CMP) begin : g_shared
      logic [XLEN:0] diff;
      logic          borrow;
      assign diff   = {1'b0, opa} - {1'b0, opb};
      assign borrow = diff[XLEN];
      assign eq_v   = (diff[XLEN-1:0] == '0);
      assign ne_v   = ~eq_v;
      assign lt_u   = borrow;
      assign ge_u   = ~borrow;
      assign lt_s   = (opa[MSB] ^ opb[MSB]) ? opa[MSB] : borrow;
      assign ge_s   = ~lt_s;
    end else begin : g_native
      assign eq_v = (opa == opb);
      assign ne_v = (opa != opb);
      assign lt_u = (opa < opb);
      assign ge_u = (opa >= opb);
      assign lt_s = ($signed(opa) < $signed(opb));
      assign ge_s = ($signed(opa) >= $signed(opb));
    end
  endgenerate

  always_comb begin
    unique case (op)
      CF_BGE:  cond_true = ge_s;
      CF_BLT:  cond_true = lt_s;
      CF_BNE:  cond_true = ne_v;
      CF_BEQ:  cond_true = eq_v;
      CF_BGEU: cond_true = ge_u;
      CF_BLTU: cond_true = lt_u;
      default: cond_true = 1'b0;
    endcase
  end

  always_comb begin
    AST_EQ_IMPLIES_GE: assert (!eq_v || (ge_s && ge_u && !ne_v))
      else $error("equal operands not seen as greater-or-equal"); // R3
    AST_SIGNED_EXCLUSIVE: assert (ge_s != lt_s)
      else $error("signed compare outputs collide"); // R3
    AST_UNSIGNED_EXCLUSIVE: assert (ge_u != lt_u)
      else $error("unsigned compare outputs collide"); // R3
    AST_SAME_SIGN_AGREE: assert ((opa[MSB] != opb[MSB]) || (lt_s == lt_u))
      else $error("same-sign operands order differently"); // R3
  end

endmodule

// File: rtl/bnpc_indirect_sel.sv
module bnpc_indirect_sel
  import bnpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cf_op_e          op,
  input  logic [XLEN-1:0] reg_a,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] ea_val,
  input  logic [XLEN-1:0] ba_val,
  output logic [XLEN-1:0] ind_pc,
  output logic            ind_hit,
  output logic            status_pulse
);

  always_comb begin
    ind_pc       = reg_a;
    ind_hit      = 1'b1;
    status_pulse = 1'b0;
    unique case (op)
      CF_JREG, CF_CREG: ind_pc = reg_a;
      CF_RETSUB:        ind_pc = ra_val;
      CF_RETBRK:        ind_pc = ba_val;
      CF_RETEXC: begin
        ind_pc       = ea_val;
        status_pulse = 1'b1;
      end
      default:          ind_hit = 1'b0;
    endcase
  end

  always_comb begin
    AST_HIT_MATCHES_CLASS: assert (ind_hit == op_is_indirect(op))
      else $error("indirect selector class mismatch"); // R7
  end

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMM16_W    = 16,
  parameter int IMM26_W    = 26,
  parameter int SEG_W      = 4,
  parameter int ALIGN_W    = 2,
  parameter int RIDX_W     = 5,
  parameter int LINK_REG   = 31,
  parameter bit SHARED_CMP = 1'b1
) (
  input  logic [XLEN-1:0]    pc_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [XLEN-1:0]    rs_a_i,
  input  logic [XLEN-1:0]    rs_b_i,
  input  logic [IMM16_W-1:0] imm16_i,
  input  logic [IMM26_W-1:0] imm26_i,
  input  logic [RIDX_W-1:0]  rc_idx_i,
  input  logic [XLEN-1:0]    ra_val_i,
  input  logic [XLEN-1:0]    ea_val_i,
  input  logic [XLEN-1:0]    ba_val_i,
  output logic               taken_o,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               link_we_o,
  output logic [RIDX_W-1:0]  link_idx_o,
  output logic [XLEN-1:0]    link_val_o,
  output logic               status_restore_o
);

  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);
  localparam logic [RIDX_W-1:0] ZERO_IDX = '0;

  cf_op_e op;
  assign op = cf_op_e'(op_i);

  logic [XLEN-1:0] seq_pc, rel_pc, abs_pc, ind_pc;
  logic            cond_true, ind_hit, status_pulse;

  bnpc_target_gen #(
    .XLEN(XLEN), .IMM16_W(IMM16_W), .IMM26_W(IMM26_W),
    .SEG_W(SEG_W), .ALIGN_W(ALIGN_W)
  ) u_tgt (
    .pc(pc_i), .imm16(imm16_i), .imm26(imm26_i),
    .seq_pc(seq_pc), .rel_pc(rel_pc), .abs_pc(abs_pc)
  );

  bnpc_cond_eval #(.XLEN(XLEN), .SHARED_CMP(SHARED_CMP)) u_cmp (
    .op(op), .opa(rs_a_i), .opb(rs_b_i), .cond_true(cond_true)
  );

  bnpc_indirect_sel #(.XLEN(XLEN)) u_ind (
    .op(op), .reg_a(rs_a_i), .ra_val(ra_val_i), .ea_val(ea_val_i),
    .ba_val(ba_val_i), .ind_pc(ind_pc), .ind_hit(ind_hit),
    .status_pulse(status_pulse)
  );

  tgt_sel_e sel;
  logic     link_req;

  always_comb begin
    sel        = TGT_SEQ;
    link_req   = 1'b0;
    link_idx_o = LINK_IDX;
    unique case (op)
      CF_BR:            sel = TGT_REL;
      CF_BGE, CF_BLT, CF_BNE, CF_BEQ, CF_BGEU, CF_BLTU:
                        sel = cond_true ? TGT_REL : TGT_SEQ;
      CF_JABS:          sel = TGT_ABS;
      CF_CABS: begin
        sel      = TGT_ABS;
        link_req = 1'b1;
      end
      CF_CREG: begin
        sel      = TGT_IND;
        link_req = 1'b1;
      end
      CF_JREG, CF_RETSUB, CF_RETBRK, CF_RETEXC:
                        sel = TGT_IND;
      CF_NEXTPC: begin
        link_idx_o = rc_idx_i;
        link_req   = (rc_idx_i != ZERO_IDX);
      end
      default:          sel = TGT_SEQ;
    endcase
  end

  always_comb begin
    unique case (sel)
      TGT_REL: next_pc_o = rel_pc;
      TGT_ABS: next_pc_o = abs_pc;
      TGT_IND: next_pc_o = ind_pc;
      default: next_pc_o = seq_pc;
    endcase
  end

  assign taken_o          = (sel != TGT_SEQ);
  assign link_we_o        = link_req;
  assign link_val_o       = seq_pc;
  assign status_restore_o = status_pulse;

  always_comb begin
    AST_SEQ_WHEN_NOT_TAKEN: assert (taken_o || (next_pc_o == pc_i + XLEN'(1 << ALIGN_W)))
      else $error("untaken flow left sequential path"); // R1
    AST_COND_FALSE_NOT_TAKEN: assert (!op_is_cond(op) || cond_true || !taken_o)
      else $error("false condition redirected"); // R3
    AST_REG_JUMP_UNCHANGED: assert (!(op == CF_JREG || op == CF_CREG) || (next_pc_o == rs_a_i))
      else $error("register target altered"); // R6
    AST_RESTORE_ONLY_ON_ERET: assert (!status_restore_o || (op == CF_RETEXC && taken_o && next_pc_o == ea_val_i))
      else $error("status restore outside exception return"); // R8
    AST_NEXTPC_ZERO_DROPPED: assert (!(op == CF_NEXTPC && rc_idx_i == ZERO_IDX) || !link_we_o)
      else $error("write to register zero requested"); // R9
    AST_LINK_OPS_ONLY: assert (!link_we_o || op == CF_CABS || op == CF_CREG || op == CF_NEXTPC)
      else $error("link write from non-linking operation"); // R10
    AST_CALL_LINKS_RA: assert (!link_we_o || op == CF_NEXTPC || link_idx_o == LINK_IDX)
      else $error("call link to wrong register"); // R5
    AST_IND_PATH_USED: assert (!ind_hit || taken_o)
      else $error("indirect operation not taken"); // R7
  end

endmodule

// File: tb/tb_bnpc_unit.sv
module tb_bnpc_unit;
  import bnpc_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pc_i, rs_a_i, rs_b_i, ra_val_i, ea_val_i, ba_val_i;
  logic [3:0]  op_i;
  logic [15:0] imm16_i;
  logic [25:0] imm26_i;
  logic [4:0]  rc_idx_i;
  logic        taken_o, link_we_o, status_restore_o;
  logic [31:0] next_pc_o, link_val_o;
  logic [4:0]  link_idx_o;

  bnpc_unit dut (
    .pc_i(pc_i), .op_i(op_i), .rs_a_i(rs_a_i), .rs_b_i(rs_b_i),
    .imm16_i(imm16_i), .imm26_i(imm26_i), .rc_idx_i(rc_idx_i),
    .ra_val_i(ra_val_i), .ea_val_i(ea_val_i), .ba_val_i(ba_val_i),
    .taken_o(taken_o), .next_pc_o(next_pc_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_val_o(link_val_o),
    .status_restore_o(status_restore_o)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] pc;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] i16;
    logic [25:0] i26;
    logic [4:0]  rc;
    logic        tk;
    logic [31:0] nx;
    logic        we;
    logic [4:0]  idx;
    logic        st;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  32'h00001000, 32'h0, 32'h0, 16'h0000, 26'h0, 5'd0, 1'b0, 32'h00001004, 1'b0, 5'd0,  1'b0, 4'd1},  // R1 idle op
    '{4'd1,  32'h00001000, 32'h0, 32'h0, 16'h0010, 26'h0, 5'd0, 1'b1, 32'h00001014, 1'b0, 5'd0,  1'b0, 4'd2},  // R2 forward
    '{4'd1,  32'h00001000, 32'h0, 32'h0, 16'hFFF7, 26'h0, 5'd0, 1'b1, 32'h00000FF8, 1'b0, 5'd0,  1'b0, 4'd2},  // R2 negative, low bits cleared
    '{4'd1,  32'h00001000, 32'h0, 32'h0, 16'h0003, 26'h0, 5'd0, 1'b1, 32'h00001004, 1'b0, 5'd0,  1'b0, 4'd2},  // R2 sub-word offset
    '{4'd2,  32'h00001000, 32'hFFFFFFFF, 32'h1, 16'h0020, 26'h0, 5'd0, 1'b0, 32'h00001004, 1'b0, 5'd0, 1'b0, 4'd3},  // R3
    '{4'd2,  32'h00001000, 32'h7, 32'h7, 16'h0020, 26'h0, 5'd0, 1'b1, 32'h00001024, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd3,  32'h00001000, 32'hFFFFFFFF, 32'h1, 16'h0020, 26'h0, 5'd0, 1'b1, 32'h00001024, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd3,  32'h00001000, 32'h7, 32'h7, 16'h0020, 26'h0, 5'd0, 1'b0, 32'h00001004, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd4,  32'h00001000, 32'h5, 32'h5, 16'h0020, 26'h0, 5'd0, 1'b0, 32'h00001004, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd4,  32'h00001000, 32'h5, 32'h6, 16'h0020, 26'h0, 5'd0, 1'b1, 32'h00001024, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd5,  32'h00001000, 32'h5, 32'h5, 16'h0020, 26'h0, 5'd0, 1'b1, 32'h00001024, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd5,  32'h00001000, 32'h5, 32'h6, 16'h0020, 26'h0, 5'd0, 1'b0, 32'h00001004, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd6,  32'h00001000, 32'hFFFFFFFF, 32'h1, 16'h0020, 26'h0, 5'd0, 1'b1, 32'h00001024, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd6,  32'h00001000, 32'h1, 32'hFFFFFFFF, 16'h0020, 26'h0, 5'd0, 1'b0, 32'h00001004, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd7,  32'h00001000, 32'hFFFFFFFF, 32'h1, 16'h0020, 26'h0, 5'd0, 1'b0, 32'h00001004, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd7,  32'h00001000, 32'h1, 32'hFFFFFFFF, 16'h0020, 26'h0, 5'd0, 1'b1, 32'h00001024, 1'b0, 5'd0, 1'b0, 4'd3},
    '{4'd8,  32'hA0001000, 32'h0, 32'h0, 16'h0, 26'h0123456, 5'd0, 1'b1, 32'hA048D158, 1'b0, 5'd0, 1'b0, 4'd4},  // R4
    '{4'd8,  32'h50000000, 32'h0, 32'h0, 16'h0, 26'h3FFFFFF, 5'd0, 1'b1, 32'h5FFFFFFC, 1'b0, 5'd0, 1'b0, 4'd4},  // R4 full field
    '{4'd9,  32'h20000100, 32'h0, 32'h0, 16'h0, 26'h0000040, 5'd0, 1'b1, 32'h20000100, 1'b1, 5'd31, 1'b0, 4'd5},  // R5
    '{4'd10, 32'h00001000, 32'h00003003, 32'h0, 16'h0, 26'h0, 5'd0, 1'b1, 32'h00003003, 1'b0, 5'd0, 1'b0, 4'd6},  // R6 unaligned
    '{4'd11, 32'h00001000, 32'h80000002, 32'h0, 16'h0, 26'h0, 5'd0, 1'b1, 32'h80000002, 1'b1, 5'd31, 1'b0, 4'd6},
    '{4'd12, 32'h00001000, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0, 1'b1, 32'h00001230, 1'b0, 5'd0, 1'b0, 4'd7},  // R7
    '{4'd13, 32'h00001000, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0, 1'b1, 32'h00007890, 1'b0, 5'd0, 1'b0, 4'd7},
    '{4'd14, 32'h00001000, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0, 1'b1, 32'h00004560, 1'b0, 5'd0, 1'b1, 4'd8},  // R8
    '{4'd15, 32'h00001000, 32'h0, 32'h0, 16'h0, 26'h0, 5'd7, 1'b0, 32'h00001004, 1'b1, 5'd7, 1'b0, 4'd9},  // R9
    '{4'd15, 32'h00001000, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0, 1'b0, 32'h00001004, 1'b0, 5'd0, 1'b0, 4'd9},  // R9 zero dest
    '{4'd0,  32'hFFFFFFFC, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0, 1'b0, 32'h00000000, 1'b0, 5'd0, 1'b0, 4'd11}, // R11
    '{4'd1,  32'hFFFFFFF8, 32'h0, 32'h0, 16'h0008, 26'h0, 5'd0, 1'b1, 32'h00000004, 1'b0, 5'd0, 1'b0, 4'd11}, // R11
    '{4'd2,  32'h00001000, 32'h80000000, 32'h7FFFFFFF, 16'h0020, 26'h0, 5'd0, 1'b0, 32'h00001004, 1'b0, 5'd0, 1'b0, 4'd3}  // R3 extremes
  };

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i16, input logic [25:0] i26,
                       input logic [4:0] rc);
    @(negedge clk);
    op_i = op; pc_i = pc; rs_a_i = a; rs_b_i = b;
    imm16_i = i16; imm26_i = i26; rc_idx_i = rc;
    #2;
  endtask

  initial begin
    ra_val_i = 32'h00001230;
    ea_val_i = 32'h00004560;
    ba_val_i = 32'h00007890;
    op_i = '0; pc_i = '0; rs_a_i = '0; rs_b_i = '0;
    imm16_i = '0; imm26_i = '0; rc_idx_i = '0;

    // Idle state with all inputs at zero (R1, R8, R10)
    drive(4'd0, 32'h0, 32'h0, 32'h0, 16'h0, 26'h0, 5'd0);
    check("R1", "idle taken", 32'(taken_o), 32'd0);
    check("R1", "idle next", next_pc_o, 32'h00000004);
    check("R10", "idle link_we", 32'(link_we_o), 32'd0);
    check("R8", "idle restore", 32'(status_restore_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].req);
      drive(VEC[i].op, VEC[i].pc, VEC[i].a, VEC[i].b, VEC[i].i16, VEC[i].i26, VEC[i].rc);
      check(rq, $sformatf("vec%0d taken", i), 32'(taken_o), 32'(VEC[i].tk));
      check(rq, $sformatf("vec%0d next", i), next_pc_o, VEC[i].nx);
      check(rq, $sformatf("vec%0d link_we", i), 32'(link_we_o), 32'(VEC[i].we));
      check(rq, $sformatf("vec%0d restore", i), 32'(status_restore_o), 32'(VEC[i].st));
      if (VEC[i].we) begin
        check(rq, $sformatf("vec%0d link_idx", i), 32'(link_idx_o), 32'(VEC[i].idx));
        check(rq, $sformatf("vec%0d link_val", i), link_val_o, VEC[i].pc + 32'd4);
      end
    end

    // Sweep every op code: restore strobe only on 14 (R8), link only on 9, 11, 15 (R10)
    for (int k = 0; k < 16; k++) begin
      logic exp_we;
      exp_we = (k == 9) || (k == 11) || (k == 15);
      drive(4'(k), 32'h00400000, 32'h0, 32'h0, 16'h0, 26'h0, 5'd3);
      check("R8", $sformatf("op%0d restore", k), 32'(status_restore_o), 32'(k == 14));
      check("R10", $sformatf("op%0d link_we", k), 32'(link_we_o), 32'(exp_we));
      if (exp_we)
        check("R10", $sformatf("op%0d link_val", k), link_val_o, 32'h00400004);
    end

    // Register call with unaligned target keeps the low bits (R6)
    drive(4'd11, 32'hFFFFFFFC, 32'h00000001, 32'h0, 16'h0, 26'h0, 5'd0);
    check("R6", "creg next", next_pc_o, 32'h00000001);
    check("R11", "creg link wraps", link_val_o, 32'h00000000);

    // Branch condition false takes the sequential path even with large offset (R1)
    drive(4'd5, 32'h00002000, 32'h1, 32'h2, 16'h7FFC, 26'h0, 5'd0);
    check("R1", "beq false next", next_pc_o, 32'h00002004);
    drive(4'd5, 32'h00002000, 32'h2, 32'h2, 16'h7FFC, 26'h0, 5'd0);
    check("R2", "beq true max", next_pc_o, 32'h0000A000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule